// File: doc/BRIEF.md
# Serial Audio Data Port Pair

This block connects a serial stereo audio link to a parallel sample interface in both directions. The receive side watches a bit clock, a left/right clock, a word clock and a data line. It rebuilds each channel word of up to 16 bits and presents a completed left/right pair on parallel outputs. The transmit side takes a 24-bit left word and a 24-bit right word from parallel inputs and shifts them out MSB first, framed by its own bit clock, left/right clock and word clock.

Each side has its own two framing-select pins and its own bit clock polarity pin. Four framings are available: data starting at the frame edge, data delayed by one bit clock, data starting 16 bit clocks after the frame edge, and data aligned to a rising word clock. All serial signals are oversampled by the system clock `clk`, so a bit clock half period must last at least three `clk` cycles. A receiver downstream of the transmit side may use as many leading bits of each 24-bit word as it needs. A mute input forces the transmitted data to zero.

Top module: `sap_port`

## Requirements
- R1: While `rstN` is low and right after it, `rxValid`, `rxLeft`, `rxRight` and `txData` are all zero.
- R2: With `rxMode` = 00, a word begins at the first active receive edge where `rxLrck` differs from its level at the previous active edge, and that edge carries the MSB. `rxLrck` high at that edge marks a left word and low marks a right word.
- R3: With `rxMode` = 01, the MSB is taken one active edge after the edge at which the `rxLrck` change is seen.
- R4: With `rxMode` = 10, the MSB is taken 16 active edges after the edge at which the `rxLrck` change is seen.
- R5: With `rxMode` = 11, a word begins at the first active edge where `rxWclk` is high after being low at the previous active edge, and that edge carries the MSB. The `rxLrck` level at that edge picks the channel, and `rxLrck` transitions alone start no word.
- R6: A received word that ends before 16 bits reads back with zeros in the missing LSBs. Bits after the 16th bit of a word are ignored.
- R7: With a polarity pin at 0, the receive side samples on the rising bit clock edge and the transmit side changes `txData` on the falling edge. With the pin at 1 these edges are swapped.
- R8: The transmit side loads `txLeft` (when `txLrck` is high) or `txRight` (when it is low) at the start of each word. It then sends 24 bits MSB first, one per inactive `txBclk` edge. The first bit goes out at the same offsets as in R2 to R5, counted in inactive edges. `txData` is low after the 24th bit until the next word starts.
- R9: While `muteIn` is high at a launching edge, the bit launched is 0.
- R10: `rxValid` pulses for one `clk` cycle when a right word is closed by the start of the next word. `rxLeft` and `rxRight` change only in that cycle and hold the most recent left word and that right word.
- R11: The receive and transmit sides work at the same time with different modes and polarities without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all serial signals |
| rstN | input | 1 | Asynchronous active-low reset |
| rxBclk | input | 1 | Receive bit clock |
| rxLrck | input | 1 | Receive left/right clock, high = left |
| rxWclk | input | 1 | Receive word clock, used in mode 11 |
| rxData | input | 1 | Receive serial data |
| rxMode | input | 2 | Receive framing select (00, 01, 10, 11) |
| rxBpol | input | 1 | Receive bit clock polarity |
| rxLeft | output | 16 | Last received left word |
| rxRight | output | 16 | Last received right word |
| rxValid | output | 1 | One-cycle strobe for a new pair |
| txBclk | input | 1 | Transmit bit clock |
| txLrck | input | 1 | Transmit left/right clock, high = left |
| txWclk | input | 1 | Transmit word clock, used in mode 11 |
| txMode | input | 2 | Transmit framing select |
| txBpol | input | 1 | Transmit bit clock polarity |
| txLeft | input | 24 | Left word to transmit |
| txRight | input | 24 | Right word to transmit |
| muteIn | input | 1 | Forces transmitted bits to zero |
| txData | output | 1 | Transmit serial data |

## Verification
The hardest case to reach is word-clock framing, where word starts no longer line up with left/right transitions. The stimulus raises the word clock three bit clocks into each half-frame. A design that started words on left/right edges would then capture shifted data. A second hard case is a word that completes only when a later word starts. Each receive run therefore ends with a short extra half-frame that closes the last right word, and the bench then checks that every expected pair appeared. Short words, with ones driven after the 16th bit, exercise zero fill and the discarding of extra bits. A concurrent run with different settings on each side shows that the two sides do not interact.

// File: rtl/sap_pkg.sv
package sap_pkg;

  // width of every position counter and bit index
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    JUST_EDGE   = 2'b00,
    JUST_DELAY1 = 2'b01,
    JUST_LATE   = 2'b10,
    JUST_WORD   = 2'b11
  } justMode_e;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] bitIdx;
    logic             wordStart;
    logic             closeLeft;
    logic             closeRight;
  } rxStrobe_t;

  typedef struct packed {
    logic             launch;
    logic             load;
    logic             loadLeft;
    logic             bitOn;
    logic [IDX_W-1:0] bitIdx;
  } txStrobe_t;

  // bit-clock distance from the start event to the MSB
  function automatic logic [IDX_W-1:0] leadOf(input logic [1:0] m,
                                              input logic [IDX_W-1:0] lateLead);
    case (justMode_e'(m))
      JUST_DELAY1: return IDX_W'(1);
      JUST_LATE:   return lateLead;
      default:     return '0;
    endcase
  endfunction

endpackage

// File: rtl/sap_rx_ctrl.sv
module sap_rx_ctrl import sap_pkg::*; #(
  parameter int IN_W    = 16,
  parameter int RJ_LEAD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclk,
  input  logic       lrck,
  input  logic       wclk,
  input  logic [1:0] mode,
  input  logic       bpol,
  output rxStrobe_t  strb
);

  localparam logic [IDX_W-1:0] CNT_TOP  = '1;
  localparam logic [IDX_W-1:0] LATE_POS = IDX_W'(RJ_LEAD);
  localparam logic [IDX_W-1:0] WORD_LIM = IDX_W'(IN_W);
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(IN_W - 1);

  logic bclkQ, bclkPrev, lrQ, wcQ, lrLast, wcLast, armed, chan;
  logic [IDX_W-1:0] cnt, pos, off, rel;
  logic activeEv, startEv, inWord;

  always_comb begin
    activeEv = (bclkQ ^ bclkPrev) && (bclkQ == !bpol);
    if (justMode_e'(mode) == JUST_WORD)
      startEv = activeEv && wcQ && !wcLast;
    else
      startEv = activeEv && (lrQ != lrLast);
    off    = leadOf(mode, LATE_POS);
    pos    = startEv ? '0 : ((cnt == CNT_TOP) ? cnt : cnt + 1'b1);
    rel    = pos - off;
    inWord = (pos >= off) && (rel < WORD_LIM);

    strb.capture    = activeEv && inWord && (armed || startEv);
    strb.bitIdx     = MSB_IDX - rel;
    strb.wordStart  = startEv;
    strb.closeLeft  = startEv && armed && chan;
    strb.closeRight = startEv && armed && !chan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ    <= 1'b0;
      bclkPrev <= 1'b0;
      lrQ      <= 1'b0;
      wcQ      <= 1'b0;
      lrLast   <= 1'b0;
      wcLast   <= 1'b0;
      armed    <= 1'b0;
      chan     <= 1'b0;
      cnt      <= '0;
    end else begin
      bclkQ    <= bclk;
      bclkPrev <= bclkQ;
      lrQ      <= lrck;
      wcQ      <= wclk;
      if (activeEv) begin
        lrLast <= lrQ;
        wcLast <= wcQ;
        cnt    <= pos;
      end
      if (startEv) begin
        armed <= 1'b1;
        chan  <= lrQ;
      end
    end
  end

  // R7: data is only taken on the selected bit clock level
  assert_capture_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (bclkQ == !bpol) && (bclkPrev == bpol))
    else $error("capture outside active edge");

endmodule

// File: rtl/sap_rx_dp.sv
module sap_rx_dp import sap_pkg::*; #(
  parameter int IN_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            din,
  input  rxStrobe_t       strb,
  output logic [IN_W-1:0] leftOut,
  output logic [IN_W-1:0] rightOut,
  output logic            pairValid
);

  logic dataQ;
  logic [IN_W-1:0] word, nextWord, leftHold;

  always_comb begin
    nextWord = strb.wordStart ? '0 : word;
    if (strb.capture) begin
      for (int i = 0; i < IN_W; i++) begin
        if (strb.bitIdx == IDX_W'(i)) nextWord[i] = dataQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ     <= 1'b0;
      word      <= '0;
      leftHold  <= '0;
      leftOut   <= '0;
      rightOut  <= '0;
      pairValid <= 1'b0;
    end else begin
      dataQ     <= din;
      word      <= nextWord;
      pairValid <= strb.closeRight;
      if (strb.closeLeft) leftHold <= word;
      if (strb.closeRight) begin
        leftOut  <= leftHold;
        rightOut <= word;
      end
    end
  end

  // R10: the pair strobe lasts one cycle
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid)
    else $error("valid longer than one cycle");

  // R10: outputs move only when a right word closes
  assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.closeRight |=> $stable(leftOut) && $stable(rightOut))
    else $error("pair changed without close");

  // R6: a new word starts from all zeros unless its MSB arrives at once
  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordStart && !strb.capture) |=> (word == '0))
    else $error("word not cleared at start");

endmodule

// File: rtl/sap_tx_ctrl.sv
module sap_tx_ctrl import sap_pkg::*; #(
  parameter int OUT_W   = 24,
  parameter int RJ_LEAD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclk,
  input  logic       lrck,
  input  logic       wclk,
  input  logic [1:0] mode,
  input  logic       bpol,
  output txStrobe_t  strb
);

  localparam logic [IDX_W-1:0] CNT_TOP  = '1;
  localparam logic [IDX_W-1:0] LATE_POS = IDX_W'(RJ_LEAD);
  localparam logic [IDX_W-1:0] WORD_LIM = IDX_W'(OUT_W);
  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(OUT_W - 1);

  logic bclkQ, bclkPrev, lrQ, wcQ, lrLast, wcLast;
  logic [IDX_W-1:0] cnt, pos, off, rel;
  logic launchEv, startEv;

  always_comb begin
    launchEv = (bclkQ ^ bclkPrev) && (bclkQ == bpol);
    if (justMode_e'(mode) == JUST_WORD)
      startEv = launchEv && wcQ && !wcLast;
    else
      startEv = launchEv && (lrQ != lrLast);
    off = leadOf(mode, LATE_POS);
    pos = startEv ? '0 : ((cnt == CNT_TOP) ? cnt : cnt + 1'b1);
    rel = pos - off;

    strb.launch   = launchEv;
    strb.load     = startEv;
    strb.loadLeft = lrQ;
    strb.bitOn    = (pos >= off) && (rel < WORD_LIM);
    strb.bitIdx   = MSB_IDX - rel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ    <= 1'b0;
      bclkPrev <= 1'b0;
      lrQ      <= 1'b0;
      wcQ      <= 1'b0;
      lrLast   <= 1'b0;
      wcLast   <= 1'b0;
      cnt      <= '0;
    end else begin
      bclkQ    <= bclk;
      bclkPrev <= bclkQ;
      lrQ      <= lrck;
      wcQ      <= wclk;
      if (launchEv) begin
        lrLast <= lrQ;
        wcLast <= wcQ;
        cnt    <= pos;
      end
    end
  end

  // R7: launches happen only on the inactive bit clock level
  assert_launch_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |-> (bclkPrev == !bpol))
    else $error("launch on wrong edge");

endmodule

// File: rtl/sap_tx_dp.sv
module sap_tx_dp import sap_pkg::*; #(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OUT_W-1:0] leftIn,
  input  logic [OUT_W-1:0] rightIn,
  input  logic             mute,
  input  txStrobe_t        strb,
  output logic             dout
);

  logic [OUT_W-1:0] curWord, srcWord;
  logic bitVal;

  always_comb begin
    if (strb.load) srcWord = strb.loadLeft ? leftIn : rightIn;
    else           srcWord = curWord;
    bitVal = 1'b0;
    for (int i = 0; i < OUT_W; i++) begin
      if (strb.bitIdx == IDX_W'(i)) bitVal = srcWord[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord <= '0;
      dout    <= 1'b0;
    end else begin
      if (strb.load) curWord <= srcWord;
      if (strb.launch) dout <= strb.bitOn && !mute && bitVal;
    end
  end

  // R9: muted launches give zero
  assert_mute_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && mute) |=> !dout)
    else $error("muted bit not zero");

  // R8: data line changes only on a launch
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.launch |=> $stable(dout))
    else $error("data moved between launches");

  // R8: past the last word bit the line is low
  assert_tail_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && !strb.bitOn) |=> !dout)
    else $error("tail bit not low");

endmodule

// File: rtl/sap_port.sv
module sap_port import sap_pkg::*; #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 24,
  parameter int RJ_LEAD = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBclk,
  input  logic             rxLrck,
  input  logic             rxWclk,
  input  logic             rxData,
  input  logic [1:0]       rxMode,
  input  logic             rxBpol,
  output logic [IN_W-1:0]  rxLeft,
  output logic [IN_W-1:0]  rxRight,
  output logic             rxValid,
  input  logic             txBclk,
  input  logic             txLrck,
  input  logic             txWclk,
  input  logic [1:0]       txMode,
  input  logic             txBpol,
  input  logic [OUT_W-1:0] txLeft,
  input  logic [OUT_W-1:0] txRight,
  input  logic             muteIn,
  output logic             txData
);

  rxStrobe_t rxStrb;
  txStrobe_t txStrb;

  sap_rx_ctrl #(.IN_W(IN_W), .RJ_LEAD(RJ_LEAD)) uRxCtrl (
    .clk(clk), .rstN(rstN), .bclk(rxBclk), .lrck(rxLrck), .wclk(rxWclk),
    .mode(rxMode), .bpol(rxBpol), .strb(rxStrb));

  sap_rx_dp #(.IN_W(IN_W)) uRxDp (
    .clk(clk), .rstN(rstN), .din(rxData), .strb(rxStrb),
    .leftOut(rxLeft), .rightOut(rxRight), .pairValid(rxValid));

  sap_tx_ctrl #(.OUT_W(OUT_W), .RJ_LEAD(RJ_LEAD)) uTxCtrl (
    .clk(clk), .rstN(rstN), .bclk(txBclk), .lrck(txLrck), .wclk(txWclk),
    .mode(txMode), .bpol(txBpol), .strb(txStrb));

  sap_tx_dp #(.OUT_W(OUT_W)) uTxDp (
    .clk(clk), .rstN(rstN), .leftIn(txLeft), .rightIn(txRight),
    .mute(muteIn), .strb(txStrb), .dout(txData));

endmodule

// File: tb/sim_sap_port.sv
module sim_sap_port;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxBclk = 1'b0, rxLrck = 1'b0, rxWclk = 1'b0, rxData = 1'b0, rxBpol = 1'b0;
  logic [1:0] rxMode = 2'b00;
  logic [15:0] rxLeft, rxRight;
  logic rxValid;
  logic txBclk = 1'b0, txLrck = 1'b0, txWclk = 1'b0, txBpol = 1'b0, muteIn = 1'b0;
  logic [1:0] txMode = 2'b00;
  logic [23:0] txLeft = '0, txRight = '0;
  logic txData;

  int nCompared = 0;
  int nMismatched = 0;
  bit done = 1'b0;
  string curReq = "R2";
  logic [31:0] expQ[$];
  logic [15:0] lastL, lastR;

  always #5 clk = ~clk;

  sap_port u0 (
    .clk(clk), .rstN(rstN),
    .rxBclk(rxBclk), .rxLrck(rxLrck), .rxWclk(rxWclk), .rxData(rxData),
    .rxMode(rxMode), .rxBpol(rxBpol), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxValid(rxValid),
    .txBclk(txBclk), .txLrck(txLrck), .txWclk(txWclk), .txMode(txMode),
    .txBpol(txBpol), .txLeft(txLeft), .txRight(txRight), .muteIn(muteIn),
    .txData(txData));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int leadFor(input int m);
    case (m)
      1: return 1;
      2: return 16;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  // receive-side reference: every clock, a pair appears only as predicted (R10)
  always @(negedge clk) begin
    if (!rstN) begin
      lastL = '0;
      lastR = '0;
    end else if (rxValid) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected pair", {rxLeft, rxRight}, 32'hxxxxxxxx);
      end else begin
        check(curReq, {rxLeft, rxRight}, expQ.pop_front());
      end
      lastL = rxLeft;
      lastR = rxRight;
    end else begin
      check("R10 hold", {rxLeft, rxRight}, {lastL, lastR});
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rxHalf(input logic lr, input logic [15:0] w, input int len,
                        input int lead, input int nBits);
    for (int p = 0; p < nBits; p++) begin
      int d;
      d = p - lead;
      @(negedge clk);
      rxBclk = rxBpol;
      rxLrck = lr;
      rxWclk = (p >= 3 && p <= 5);
      if (d >= 0 && d < len) rxData = w[len-1-d];
      else rxData = (d >= 16);
      repeat (4) @(negedge clk);
      rxBclk = ~rxBpol;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic rxRun(input int m, input logic pol, input int len, input int nFr,
                       input string req, input bit rst);
    rxMode = 2'(m);
    rxBpol = pol;
    rxBclk = ~pol;
    rxLrck = 1'b0;
    rxWclk = 1'b0;
    if (rst) doReset();
    curReq = req;
    for (int f = 0; f < nFr; f++) begin
      logic [15:0] l, r;
      l = 16'($urandom) & 16'((1 << len) - 1);
      r = 16'($urandom) & 16'((1 << len) - 1);
      rxHalf(1'b1, l, len, leadFor(m), 32);
      rxHalf(1'b0, r, len, leadFor(m), 32);
      expQ.push_back({16'(l << (16 - len)), 16'(r << (16 - len))});
    end
    rxHalf(1'b1, 16'h0, len, leadFor(m), 6);
    repeat (20) @(negedge clk);
    check({req, " R10 pairs outstanding"}, expQ.size(), 0);
  endtask

  task automatic txHalf(input logic lr, input logic [23:0] w, input int lead,
                        input logic mute, input string req);
    for (int p = 0; p < 32; p++) begin
      int d;
      logic expBit;
      d = p - lead;
      @(negedge clk);
      txBclk = txBpol;
      txLrck = lr;
      txWclk = (p >= 3 && p <= 5);
      muteIn = mute;
      repeat (4) @(negedge clk);
      expBit = (!mute && d >= 0 && d < 24) ? w[23-d] : 1'b0;
      check(req, {31'h0, txData}, {31'h0, expBit});
      txBclk = ~txBpol;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic txRun(input int m, input logic pol, input int nFr, input int muteFr,
                       input string req, input bit rst);
    txMode = 2'(m);
    txBpol = pol;
    txBclk = ~pol;
    txLrck = 1'b0;
    txWclk = 1'b0;
    muteIn = 1'b0;
    if (rst) doReset();
    for (int f = 0; f < nFr; f++) begin
      logic [23:0] l, r;
      l = 24'($urandom);
      r = 24'($urandom);
      txLeft = l;
      txRight = r;
      txHalf(1'b1, l, leadFor(m), f == muteFr, req);
      txHalf(1'b0, r, leadFor(m), f == muteFr, req);
    end
    muteIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state with busy inputs
    rxData = 1'b1;
    txLeft = 24'hFFFFFF;
    txRight = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    check("R1 rxValid", {31'h0, rxValid}, 0);
    check("R1 rxLeft", {16'h0, rxLeft}, 0);
    check("R1 rxRight", {16'h0, rxRight}, 0);
    check("R1 txData", {31'h0, txData}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {rxValid, txData, rxLeft, rxRight}, 0);

    rxRun(0, 1'b0, 16, 3, "R2", 1'b1);
    rxRun(1, 1'b0, 16, 3, "R3", 1'b1);
    rxRun(2, 1'b1, 16, 3, "R4", 1'b1);
    rxRun(3, 1'b0, 16, 3, "R5", 1'b1);
    rxRun(0, 1'b0, 4, 3, "R6", 1'b1);
    rxRun(2, 1'b0, 9, 2, "R6", 1'b1);
    rxRun(0, 1'b1, 12, 2, "R7", 1'b1);

    txRun(0, 1'b0, 2, -1, "R8", 1'b1);
    txRun(1, 1'b1, 2, -1, "R7", 1'b1);
    txRun(2, 1'b0, 2, -1, "R8", 1'b1);
    txRun(3, 1'b0, 2, -1, "R8", 1'b1);
    txRun(0, 1'b0, 3, 1, "R9", 1'b1);

    // R11: both sides at once with different settings
    rxMode = 2'd2; rxBpol = 1'b0; rxBclk = 1'b1; rxLrck = 1'b0; rxWclk = 1'b0;
    txMode = 2'd1; txBpol = 1'b1; txBclk = 1'b0; txLrck = 1'b0; txWclk = 1'b0;
    doReset();
    fork
      rxRun(2, 1'b0, 16, 3, "R11", 1'b0);
      txRun(1, 1'b1, 3, -1, "R11", 1'b0);
    join

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule